// File: doc/BRIEF.md
# Push-Button Tap Position Controller

This block turns two active-low push buttons into a 5-bit tap position for a 32-step resistor ladder. Each button input is synchronized and debounced. A short press moves the position one tap up or down. A button held down repeats at a slow rate first, then at a fast rate once the hold passes a mode-switch time. The position stops at both ends of the range and never wraps.

Holding both buttons together for the shutdown time puts the block into a low-power state. In that state the effective tap is forced to zero and a flag opens the top end of the ladder. If the two buttons go down too far apart in time, the block ignores everything until both are released. After shutdown, a new press on either button wakes the block and restores the saved position. The waking press does not step the position. Every interval is a parameter counted in clock cycles.

The control is one state machine:
- `ST_IDLE`: no button is down.
- `ST_ARM`: one button is down and the pairing window is still open.
- `ST_RPT`: a single button is held and auto-repeat is running.
- `ST_PAIR`: both buttons are down and the shutdown timer is running.
- `ST_LOCK`: a rejected combination was seen; waiting for both buttons to be released.
- `ST_SD_HELD`: shutdown with the buttons still down.
- `ST_SD_IDLE`: shutdown with the buttons released.
- `ST_WAKE`: a wake press is being held.

Transitions:
- `ST_IDLE` → `ST_ARM` when one button is pressed.
- `ST_IDLE` → `ST_PAIR` when both buttons are pressed.
- `ST_ARM` → `ST_PAIR` when the second button arrives inside the pairing window.
- `ST_ARM` → `ST_RPT` when the window expires, with one step.
- `ST_ARM` → `ST_IDLE` when the button is released early, with one step.
- `ST_RPT` → `ST_IDLE` on release.
- `ST_RPT` → `ST_LOCK` when the other button is pressed.
- `ST_PAIR` → `ST_LOCK` when either button is released early.
- `ST_PAIR` → `ST_SD_HELD` when the shutdown time elapses.
- `ST_LOCK` → `ST_IDLE` when both buttons are released.
- `ST_SD_HELD` → `ST_SD_IDLE` when both buttons are released.
- `ST_SD_IDLE` → `ST_WAKE` on any press.
- `ST_WAKE` → `ST_IDLE` when both buttons are released.

Top module: `btn_tap_ctrl`

## Requirements
- R1: Both button inputs are active low and idle high. Each passes through a two-flop synchronizer. A low level lasting fewer than DEB_CYC cycles has no effect on the position or the shutdown flag.
- R2: A single debounced press of the up button raises the position by one tap. A single debounced press of the down button lowers it by one tap. The step is applied SKEW_CYC cycles into the press, or at release if the release comes sooner.
- R3: The position is an unsigned value from 0 to 31. It changes by at most one tap per cycle, saturates at 0 and 31, and never wraps.
- R4: After reset the effective position is 0, the select vector is 32'h0000_0001, and the top-disconnect flag is low.
- R5: While one button stays held and the hold is shorter than MODE_CYC cycles, the position steps again every SLOW_CYC cycles after the first step.
- R6: Once the hold reaches MODE_CYC cycles, the position steps every FAST_CYC cycles. After release, the position makes no further steps.
- R7: If both buttons go down within SKEW_CYC cycles of each other and stay down together for SHDN_CYC cycles, the block enters shutdown. In shutdown the effective position output is 0, the select vector is 32'h0000_0001, and the top-disconnect flag is 1. No step happens during the pairing.
- R8: If the second button arrives more than SKEW_CYC cycles after the first, every command is ignored until both buttons are high again. The same holds if a pair is released before shutdown. Steps already made by the first button alone stand.
- R9: In shutdown, once both buttons have been released, a debounced press of either button exits shutdown. The position held before shutdown is then restored to the outputs.
- R10: The select vector has exactly one bit set, at the index equal to the effective position output.
- R11: The press that wakes the block from shutdown never steps the position, however long it is held. Only a later press steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_btn_ni | input | 1 | Raw up button, low when pressed |
| dn_btn_ni | input | 1 | Raw down button, low when pressed |
| tap_pos_o | output | TAP_BITS | Effective tap position (0 in shutdown) |
| tap_sel_o | output | 2**TAP_BITS | One-hot tap select |
| top_open_o | output | 1 | High while the top end of the ladder is disconnected |

## Verification
The following properties are checked on every cycle:
- The saved position only ever moves by one tap, with no wrap.
- The select vector is one-hot and agrees with the effective position.
- Shutdown always implies tap zero.
- The position is frozen while pairing, locked out, shut down or waking.
- A debounced level only ever moves toward the synchronized input.

Only the bench scenarios can show the timing-dependent behaviour:
- how many steps a hold of a given length produces at the slow and fast rates;
- the split between a near-simultaneous pair, which leads to shutdown, and a skewed pair, which is rejected;
- glitch rejection;
- restore of the saved position after wake.

// File: rtl/btn_tap_pkg.sv
`timescale 1ns/1ps
package btn_tap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RPT,
        ST_PAIR,
        ST_LOCK,
        ST_SD_HELD,
        ST_SD_IDLE,
        ST_WAKE
    } btn_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/btn_filter.sv
`timescale 1ns/1ps
module btn_filter #(
    parameter int unsigned DEB_CYC = 15000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_ni,
    output logic pressed_o
);
    localparam int unsigned DW = $clog2(DEB_CYC + 1);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYC - 1);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [1:0]    sync_q;
    logic [DW-1:0] cnt_q;
    logic          lvl_q;   // debounced level, 1 = released

    // two-flop synchronizer, idle high
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], raw_ni};
        end
    end

    // level follows the synchronized input only after DEB_CYC stable cycles
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (sync_q[1] == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == DEB_LAST) begin
            cnt_q <= '0;
            lvl_q <= sync_q[1];
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign pressed_o = ~lvl_q;

    // R1: the debounced level only ever moves toward the synchronized input
    a_r1_follow_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lvl_q) |-> (lvl_q == $past(sync_q[1])));

endmodule

// File: rtl/tap_onehot.sv
`timescale 1ns/1ps
module tap_onehot #(
    parameter int unsigned TAP_BITS = 5
) (
    input  logic [TAP_BITS-1:0]      idx_i,
    output logic [(1<<TAP_BITS)-1:0] sel_o
);
    localparam int unsigned TAPS = 1 << TAP_BITS;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign sel_o[i] = (idx_i == TAP_BITS'(i));
    end

    // R10: exactly one line active, at the selected index
    always_comb begin
        a_r10_onehot: assert ($countones(sel_o) == 1 && sel_o[idx_i]);
    end

endmodule

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import btn_tap_pkg::*;
#(
    parameter int unsigned TAP_BITS  = 5,
    parameter int unsigned SKEW_CYC  = 15000,
    parameter int unsigned SLOW_CYC  = 250000,
    parameter int unsigned FAST_CYC  = 50000,
    parameter int unsigned MODE_CYC  = 1000000,
    parameter int unsigned SHDN_CYC  = 2000000
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                up_i,
    input  logic                dn_i,
    output logic [TAP_BITS-1:0] pos_o,
    output logic                shdn_o
);
    localparam int unsigned LONGEST = max_of(max_of(SHDN_CYC, MODE_CYC), SLOW_CYC) + 1;
    localparam int unsigned TW = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] T_ONE      = TW'(1);
    localparam logic [TW-1:0] SKEW_LAST  = TW'(SKEW_CYC - 1);
    localparam logic [TW-1:0] SLOW_LAST  = TW'(SLOW_CYC - 1);
    localparam logic [TW-1:0] FAST_LAST  = TW'(FAST_CYC - 1);
    localparam logic [TW-1:0] MODE_T     = TW'(MODE_CYC);
    localparam logic [TW-1:0] SHDN_LAST  = TW'(SHDN_CYC - 1);
    localparam logic [TAP_BITS-1:0] P_MAX = '1;
    localparam logic [TAP_BITS-1:0] P_ONE = TAP_BITS'(1);

    btn_state_e          state_q, state_d;
    logic [TW-1:0]       tmr_q, tmr_d;      // hold duration
    logic [TW-1:0]       gap_q, gap_d;      // cycles since last step
    logic                dir_q, dir_d;      // 1 = up
    logic [TAP_BITS-1:0] pos_q;
    logic                step;
    logic                held;
    logic                any_btn;
    logic                both_btn;
    logic [TW-1:0]       ivl_last;

    assign held     = dir_q ? up_i : dn_i;
    assign any_btn  = up_i | dn_i;
    assign both_btn = up_i & dn_i;
    assign ivl_last = (tmr_q >= MODE_T) ? FAST_LAST : SLOW_LAST;

    // next-state and control
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        gap_d   = gap_q;
        dir_d   = dir_q;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_d = '0;
                gap_d = '0;
                if (both_btn) begin
                    state_d = ST_PAIR;
                end else if (any_btn) begin
                    state_d = ST_ARM;
                    dir_d   = up_i;
                end
            end
            ST_ARM: begin
                tmr_d = tmr_q + T_ONE;
                if (both_btn) begin
                    state_d = ST_PAIR;
                    tmr_d   = '0;
                end else if (!held) begin
                    step    = 1'b1;
                    state_d = ST_IDLE;
                end else if (tmr_q == SKEW_LAST) begin
                    step    = 1'b1;
                    gap_d   = '0;
                    state_d = ST_RPT;
                end
            end
            ST_RPT: begin
                tmr_d = (tmr_q >= MODE_T) ? tmr_q : tmr_q + T_ONE;
                gap_d = gap_q + T_ONE;
                if (both_btn) begin
                    state_d = ST_LOCK;
                end else if (!held) begin
                    state_d = ST_IDLE;
                end else if (gap_q >= ivl_last) begin
                    step  = 1'b1;
                    gap_d = '0;
                end
            end
            ST_PAIR: begin
                tmr_d = tmr_q + T_ONE;
                if (!both_btn) begin
                    state_d = ST_LOCK;
                end else if (tmr_q == SHDN_LAST) begin
                    state_d = ST_SD_HELD;
                end
            end
            ST_LOCK: begin
                if (!any_btn) state_d = ST_IDLE;
            end
            ST_SD_HELD: begin
                if (!any_btn) state_d = ST_SD_IDLE;
            end
            ST_SD_IDLE: begin
                if (any_btn) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (!any_btn) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            gap_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            gap_q   <= gap_d;
            dir_q   <= dir_d;
        end
    end

    // saturating position register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q <= '0;
        end else if (step) begin
            if (dir_q) begin
                if (pos_q != P_MAX) pos_q <= pos_q + P_ONE;
            end else begin
                if (pos_q != '0) pos_q <= pos_q - P_ONE;
            end
        end
    end

    // outputs
    always_comb begin
        pos_o  = pos_q;
        shdn_o = 1'b0;
        unique case (state_q)
            ST_SD_HELD, ST_SD_IDLE: shdn_o = 1'b1;
            default:                shdn_o = 1'b0;
        endcase
    end

    // R3: moves by one tap only, never wraps
    a_r3_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pos_q) |->
            (({1'b0, pos_q} == {1'b0, $past(pos_q)} + 1'b1) ||
             ({1'b0, pos_q} + 1'b1 == {1'b0, $past(pos_q)})));

    // R7: no step while a pair is being timed
    a_r7_pair_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PAIR) |=> $stable(pos_q));

    // R8: nothing moves while locked out
    a_r8_lock_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOCK) |=> $stable(pos_q));

    // R9: the saved position is untouched through shutdown
    a_r9_shdn_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SD_HELD || state_q == ST_SD_IDLE) |=> $stable(pos_q));

    // R11: the waking press does not step
    a_r11_wake_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WAKE) |=> $stable(pos_q));

    // R9: shutdown is left only through a wake press
    a_r9_exit_via_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(shdn_o) |-> (state_q == ST_WAKE));

endmodule

// File: rtl/btn_tap_ctrl.sv
`timescale 1ns/1ps
module btn_tap_ctrl #(
    parameter int unsigned TAP_BITS = 5,
    parameter int unsigned DEB_CYC  = 15000,
    parameter int unsigned SKEW_CYC = 15000,
    parameter int unsigned SLOW_CYC = 250000,
    parameter int unsigned FAST_CYC = 50000,
    parameter int unsigned MODE_CYC = 1000000,
    parameter int unsigned SHDN_CYC = 2000000
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       up_btn_ni,
    input  logic                       dn_btn_ni,
    output logic [TAP_BITS-1:0]        tap_pos_o,
    output logic [(1<<TAP_BITS)-1:0]   tap_sel_o,
    output logic                       top_open_o
);
    localparam int unsigned NBTN = 2;

    logic [NBTN-1:0]     raw_n;
    logic [NBTN-1:0]     pressed;
    logic [TAP_BITS-1:0] saved_pos;
    logic                shdn;

    assign raw_n = {dn_btn_ni, up_btn_ni};

    for (genvar b = 0; b < NBTN; b++) begin : g_btn
        btn_filter #(.DEB_CYC(DEB_CYC)) u_filt (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .raw_ni    (raw_n[b]),
            .pressed_o (pressed[b])
        );
    end

    tap_fsm #(
        .TAP_BITS (TAP_BITS),
        .SKEW_CYC (SKEW_CYC),
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC),
        .MODE_CYC (MODE_CYC),
        .SHDN_CYC (SHDN_CYC)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .up_i   (pressed[0]),
        .dn_i   (pressed[1]),
        .pos_o  (saved_pos),
        .shdn_o (shdn)
    );

    assign tap_pos_o  = shdn ? '0 : saved_pos;
    assign top_open_o = shdn;

    tap_onehot #(.TAP_BITS(TAP_BITS)) u_dec (
        .idx_i (tap_pos_o),
        .sel_o (tap_sel_o)
    );

    // R7: a disconnected top always comes with tap zero
    a_r7_open_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        top_open_o |-> (tap_pos_o == '0 && tap_sel_o[0]));

    // R9: leaving shutdown brings back the saved position
    a_r9_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(top_open_o) |-> (tap_pos_o == saved_pos));

endmodule

// File: tb/btn_tap_ctrl_bench.sv
`timescale 1ns/1ps
module btn_tap_ctrl_bench;
    localparam int DEB  = 4;
    localparam int SKEW = 6;
    localparam int SLOW = 20;
    localparam int FAST = 5;
    localparam int MODE = 60;
    localparam int SHDN = 100;
    localparam int SETTLE = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_n = 1'b1;
    logic        dn_n = 1'b1;
    logic [4:0]  tap_pos;
    logic [31:0] tap_sel;
    logic        top_open;

    int checks = 0;
    int fails  = 0;
    int exp_pos = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    btn_tap_ctrl #(
        .TAP_BITS (5),
        .DEB_CYC  (DEB),
        .SKEW_CYC (SKEW),
        .SLOW_CYC (SLOW),
        .FAST_CYC (FAST),
        .MODE_CYC (MODE),
        .SHDN_CYC (SHDN)
    ) u_btn_tap_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .up_btn_ni  (up_n),
        .dn_btn_ni  (dn_n),
        .tap_pos_o  (tap_pos),
        .tap_sel_o  (tap_sel),
        .top_open_o (top_open)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input int pos, input bit open);
        check({req, " pos"}, tap_pos, pos);
        check({req, " sel"}, tap_sel, 32'h1 << pos);
        check({req, " open"}, top_open, open);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hold one button low for n cycles, then release and settle
    task automatic hold(input bit up, input int n);
        if (up) up_n = 1'b0; else dn_n = 1'b0;
        cyc(n);
        up_n = 1'b1;
        dn_n = 1'b1;
        cyc(SETTLE);
    endtask

    function automatic int sat(input int v);
        return (v < 0) ? 0 : ((v > 31) ? 31 : v);
    endfunction

    // steps in a hold of d debounced cycles: first at SKEW-1, slow until MODE, then fast
    function automatic int steps_for(input int d);
        int n = 0;
        int t = SKEW - 1;
        int last;
        if (d <= t) return 1;
        n = 1;
        last = t;
        while (last + SLOW < MODE && last + SLOW < d) begin
            last = last + SLOW;
            n++;
        end
        if (d > MODE) begin
            last = MODE;
            n++;
            while (last + FAST < d) begin
                last = last + FAST;
                n++;
            end
        end
        return n;
    endfunction

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        check_out("R4 reset", 0, 1'b0);

        // R1: short glitches on either button
        up_n = 1'b0; cyc(DEB - 2); up_n = 1'b1; cyc(SETTLE);
        check_out("R1 up glitch", 0, 1'b0);
        dn_n = 1'b0; cyc(DEB - 2); dn_n = 1'b1; cyc(SETTLE);
        check_out("R1 dn glitch", 0, 1'b0);

        // R2: single presses
        for (int i = 0; i < 3; i++) begin
            hold(1'b1, 12);
            exp_pos = sat(exp_pos + 1);
            check_out("R2 single up", exp_pos, 1'b0);
        end
        hold(1'b0, 12);
        exp_pos = sat(exp_pos - 1);
        check_out("R2 single down", exp_pos, 1'b0);

        // R5: slow repeat, release mid-interval
        hold(1'b1, 35);
        exp_pos = sat(exp_pos + steps_for(35));
        check_out("R5 slow repeat", exp_pos, 1'b0);

        // R6: into fast repeat
        hold(1'b1, 103);
        exp_pos = sat(exp_pos + steps_for(103));
        check_out("R6 fast repeat", exp_pos, 1'b0);
        cyc(60);
        check_out("R6 idle after release", exp_pos, 1'b0);

        // R1: glitch at a mid position
        dn_n = 1'b0; cyc(DEB - 2); dn_n = 1'b1; cyc(SETTLE);
        check_out("R1 mid glitch", exp_pos, 1'b0);

        // R3: saturation at both ends
        hold(1'b1, 300);
        exp_pos = sat(exp_pos + steps_for(300));
        check_out("R3 top saturate", exp_pos, 1'b0);
        check("R3 top value", exp_pos, 31);
        hold(1'b1, 12);
        check_out("R3 no wrap up", 31, 1'b0);
        hold(1'b0, 300);
        exp_pos = sat(exp_pos - steps_for(300));
        check_out("R3 bottom saturate", exp_pos, 1'b0);
        hold(1'b0, 12);
        check_out("R3 no wrap down", 0, 1'b0);

        // sweep up one tap at a time, checking every select line
        for (int i = 1; i <= 5; i++) begin
            hold(1'b1, 12);
            exp_pos = i;
            check_out("R10 sweep", exp_pos, 1'b0);
        end

        // R8: skewed pair, first button steps alone, then lockout
        up_n = 1'b0; cyc(20);
        dn_n = 1'b0; cyc(150);
        check("R8 skew no shutdown", top_open, 0);
        up_n = 1'b1; dn_n = 1'b1; cyc(SETTLE);
        exp_pos = sat(exp_pos + 1);
        check_out("R8 skewed pair ignored", exp_pos, 1'b0);

        // R8: pair released before shutdown time
        up_n = 1'b0; dn_n = 1'b0; cyc(50);
        up_n = 1'b1; cyc(10);
        check_out("R8 early release held", exp_pos, 1'b0);
        dn_n = 1'b1; cyc(SETTLE);
        check_out("R8 early release", exp_pos, 1'b0);

        // R7: near-simultaneous pair into shutdown
        up_n = 1'b0; cyc(3);
        dn_n = 1'b0; cyc(130);
        check_out("R7 shutdown held", 0, 1'b1);
        up_n = 1'b1; dn_n = 1'b1; cyc(SETTLE);
        check_out("R7 shutdown after release", 0, 1'b1);
        dn_n = 1'b0; cyc(DEB - 2); dn_n = 1'b1; cyc(SETTLE);
        check_out("R1 glitch in shutdown", 0, 1'b1);

        // R9/R11: wake restores, no step
        hold(1'b0, 15);
        check_out("R9 R11 wake restore", exp_pos, 1'b0);
        hold(1'b1, 12);
        exp_pos = sat(exp_pos + 1);
        check_out("R11 next press steps", exp_pos, 1'b0);

        // R7 again then R11 with a long wake hold
        dn_n = 1'b0; cyc(2);
        up_n = 1'b0; cyc(130);
        check_out("R7 second shutdown", 0, 1'b1);
        up_n = 1'b1; dn_n = 1'b1; cyc(SETTLE);
        hold(1'b1, 100);
        check_out("R11 long wake no step", exp_pos, 1'b0);
        hold(1'b0, 12);
        exp_pos = sat(exp_pos - 1);
        check_out("R2 down after wake", exp_pos, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule